// File: doc/BRIEF.md
# Interrupt Distributor with Wide CPU Targets

This block collects interrupt requests from peripheral lines, per-CPU private lines and software triggers. It forwards each interrupt that is pending and enabled to one or more CPU interface outputs. Each shared interrupt carries a 16-bit CPU-target field, so one 32-bit target word holds the fields of two interrupts. Software configures the block through a 32-bit register port with separate read and write strobes. Every access completes in the cycle it is issued, and the accessing CPU is identified by an index input.

Interrupt IDs 0 to 15 are software-generated and IDs 16 to 31 are private to each CPU. IDs from 32 up to `NUM_IRQ-1` are shared and are driven by `spi_i[id-32]`. The enable state of IDs 0 to 31 is kept separately for each CPU interface. Configuration and target state are common to all CPUs. Each shared or private input is set to level-high or rising-edge sensing. Edge-sensed and software-generated interrupts stay pending until software clears them. Priority, security and power handling are not part of this block.

Top module: `irq_distributor`

## Requirements
- R1: After reset the control, enable, pending, configuration (except IDs 0-15) and shared target state are all zero, and `irq_o` is all zero.
- R2: Offset 0x004 is read-only. Bits [4:0] read `NUM_IRQ/32-1`, and all other bits read zero.
- R3: Bit 0 of offset 0x000 enables forwarding. While it is 0, every bit of `irq_o` is 0 from the clock edge after the clearing write.
- R4: For interrupt n, the enable-set bank at 0x100 and the enable-clear bank at 0x180 use word n/32, bit n%32. Writing 1 sets or clears that enable, and writing 0 has no effect. Both banks read back the current enables. For IDs 0-31 the enables belong to the CPU given by `cpu_id_i`.
- R5: The configuration bank at 0xC00 holds bit n%32 of word n/32: 1 selects rising edge and 0 selects level high. IDs 0-15 always read 1, and writes to them are ignored.
- R6: An edge-configured input sets its pending bit on a 0 to 1 transition. The bit is cleared by writing 1 to bit n%32 of word n/32 in the pending-clear bank at 0x280, which is banked by `cpu_id_i` for IDs 0-31. A set in the same cycle wins over a clear.
- R7: A level-configured interrupt is pending exactly while its input is high. Writes to the pending-clear bank do not change it.
- R8: The target bank at 0x800 holds a 16-bit CPU mask for interrupt n at byte offset (2n & ~3), in bits [15:0] for even n and [31:16] for odd n. A shared interrupt reaches `irq_o[c]` only if bit c of its mask is 1.
- R9: Reading a target word that covers IDs 0-31 returns the one-hot mask of `cpu_id_i` in both halves. Writes to those words are ignored.
- R10: A write to offset 0xF00 makes interrupt ID `wdata_i[3:0]` pending on every CPU c with `wdata_i[8+c]` set. Target bits for CPUs at or above `NUM_CPU` are ignored, and the register reads zero.
- R11: `irq_o[c]` is registered. In the cycle after any of the following holds, it is 1; otherwise it is 0: forwarding is on, and an interrupt is pending and enabled that is either private to CPU c or shared and targeted at CPU c.
- R12: Reads of unimplemented offsets return zero. `rdata_o` is zero whenever `rd_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Byte offset of the register access |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data, valid in the cycle of `rd_i` |
| cpu_id_i | input | 4 | Index of the CPU making the access |
| ppi_i | input | NUM_CPU*16 | Private lines; slice c drives IDs 16-31 of CPU c |
| spi_i | input | NUM_IRQ-32 | Shared lines; bit k drives ID 32+k |
| irq_o | output | NUM_CPU | Interrupt request per CPU interface |

## Verification
Faulty banking shows up in one of two ways: an SGI or private enable set for one CPU makes a different bit of `irq_o` rise, or a register read from one CPU returns another CPU's data. Either is visible two cycles after the write. A misplaced target half or a wrong shift of a trigger ID routes a shared or software interrupt to the wrong CPU bit, which the sweeps over every ID and CPU catch on the first affected ID. A pending bit that is not latched, or that is not cleared, appears as an `irq_o` level that is wrong one cycle after the pulse or after the clearing write.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;
  localparam int unsigned ADDR_W   = 12;
  localparam int unsigned CPU_ID_W = 4;
  localparam int unsigned TGT_W    = 16;
  localparam int unsigned SGI_N    = 16;
  localparam int unsigned PPI_N    = 16;
  localparam int unsigned PRIV_N   = 32;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_TYPE  = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_ENSET = 12'h100;
  localparam logic [ADDR_W-1:0] OFS_ENCLR = 12'h180;
  localparam logic [ADDR_W-1:0] OFS_PCLR  = 12'h280;
  localparam logic [ADDR_W-1:0] OFS_TGT   = 12'h800;
  localparam logic [ADDR_W-1:0] OFS_CFG   = 12'hC00;
  localparam logic [ADDR_W-1:0] OFS_SGI   = 12'hF00;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] line_i,
  input  logic [W-1:0] edge_i,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] prev_q, latch_q, rise;

  assign rise = line_i & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      latch_q <= '0;
    end else begin
      prev_q  <= line_i;
      // set beats clear; latched state is dropped for level inputs
      latch_q <= ((latch_q & ~clr_i) | set_i | rise) & edge_i;
    end
  end

  assign pend_o = (edge_i & latch_q) | (~edge_i & line_i);

  for (genvar i = 0; i < W; i++) begin : g_chk
    // R6
    edge_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (edge_i[i] && $rose(line_i[i])) |=> (pend_o[i] || !edge_i[i]));
    // R6
    set_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (edge_i[i] && set_i[i]) |=> (pend_o[i] || !edge_i[i]));
  end
endmodule

// File: rtl/irq_cpu_gate.sv
module irq_cpu_gate #(
  parameter int unsigned NSPI = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            glb_en_i,
  input  logic [31:0]     priv_pend_i,
  input  logic [31:0]     priv_en_i,
  input  logic [NSPI-1:0] spi_pend_i,
  input  logic [NSPI-1:0] spi_en_i,
  input  logic [NSPI-1:0] spi_tgt_i,
  output logic            irq_o
);
  logic hit;
  assign hit = (|(priv_pend_i & priv_en_i)) | (|(spi_pend_i & spi_en_i & spi_tgt_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= glb_en_i & hit;
  end

  // R3
  fwd_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glb_en_i |=> !irq_o);
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
  import irq_dist_pkg::*;
#(
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned NUM_IRQ = 64
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     wr_i,
  input  logic [31:0]              wdata_i,
  input  logic                     rd_i,
  output logic [31:0]              rdata_o,
  input  logic [CPU_ID_W-1:0]      cpu_id_i,
  input  logic [NUM_CPU*PPI_N-1:0] ppi_i,
  input  logic [NUM_IRQ-33:0]      spi_i,
  output logic [NUM_CPU-1:0]       irq_o
);
  localparam int unsigned NUM_SPI = NUM_IRQ - PRIV_N;
  localparam int unsigned NWORD   = NUM_IRQ / 32;
  localparam int unsigned NTWORD  = NUM_IRQ / 2;

  logic                ctrl_q;
  logic [PRIV_N-1:0]   en_priv_q [NUM_CPU];
  logic [NUM_SPI-1:0]  spi_en_q, spi_cfg_q, spi_pend;
  logic [PPI_N-1:0]    ppi_cfg_q;
  logic [TGT_W-1:0]    spi_tgt_q [NUM_SPI];
  logic [PRIV_N-1:0]   priv_pend [NUM_CPU];
  logic [SGI_N-1:0]    sgi_set   [NUM_CPU];

  // address decode
  logic [4:0] bank_w;
  logic [7:0] tgt_w;
  logic       in_enset, in_enclr, in_pclr, in_cfg, in_tgt, sgi_wr, cpu_ok;
  assign bank_w   = addr_i[6:2];
  assign tgt_w    = addr_i[9:2];
  assign in_enset = addr_i[11:7] == OFS_ENSET[11:7];
  assign in_enclr = addr_i[11:7] == OFS_ENCLR[11:7];
  assign in_pclr  = addr_i[11:7] == OFS_PCLR[11:7];
  assign in_cfg   = addr_i[11:7] == OFS_CFG[11:7];
  assign in_tgt   = addr_i[11:10] == OFS_TGT[11:10];
  assign sgi_wr   = wr_i && addr_i == OFS_SGI;
  assign cpu_ok   = 32'(cpu_id_i) < NUM_CPU;

  // write data placed at the addressed word of a one-bit-per-ID bank
  logic [NUM_IRQ-1:0] wmask, pclr_mask;
  always_comb begin
    wmask = '0;
    for (int w = 0; w < NWORD; w++)
      if (bank_w == 5'(w)) wmask[w*32 +: 32] = wdata_i;
  end
  assign pclr_mask = (wr_i && in_pclr) ? wmask : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= 1'b0;
      spi_en_q  <= '0;
      spi_cfg_q <= '0;
      ppi_cfg_q <= '0;
      for (int c = 0; c < NUM_CPU; c++) en_priv_q[c] <= '0;
      for (int i = 0; i < NUM_SPI; i++) spi_tgt_q[i] <= '0;
    end else if (wr_i) begin
      if (addr_i == OFS_CTRL) ctrl_q <= wdata_i[0];
      if (in_enset) begin
        spi_en_q <= spi_en_q | wmask[NUM_IRQ-1:PRIV_N];
        for (int c = 0; c < NUM_CPU; c++)
          if (cpu_id_i == CPU_ID_W'(c)) en_priv_q[c] <= en_priv_q[c] | wmask[PRIV_N-1:0];
      end
      if (in_enclr) begin
        spi_en_q <= spi_en_q & ~wmask[NUM_IRQ-1:PRIV_N];
        for (int c = 0; c < NUM_CPU; c++)
          if (cpu_id_i == CPU_ID_W'(c)) en_priv_q[c] <= en_priv_q[c] & ~wmask[PRIV_N-1:0];
      end
      if (in_cfg) begin
        if (bank_w == 5'd0) ppi_cfg_q <= wdata_i[31:16];
        for (int w = 1; w < NWORD; w++)
          if (bank_w == 5'(w)) spi_cfg_q[(w-1)*32 +: 32] <= wdata_i;
      end
      if (in_tgt) begin
        for (int i = 0; i < NUM_SPI; i++)
          if (tgt_w == 8'((i + PRIV_N) / 2))
            spi_tgt_q[i] <= (i % 2 == 0) ? wdata_i[15:0] : wdata_i[31:16];
      end
    end
  end

  // pending state and per-CPU forwarding
  logic [PRIV_N-1:0] priv_edge;
  assign priv_edge = {ppi_cfg_q, {SGI_N{1'b1}}};

  irq_pend_bank #(.W(NUM_SPI)) u_spi_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (spi_i),
    .edge_i (spi_cfg_q),
    .set_i  ('0),
    .clr_i  (pclr_mask[NUM_IRQ-1:PRIV_N]),
    .pend_o (spi_pend)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [PRIV_N-1:0]  priv_clr;
    logic [NUM_SPI-1:0] tgt_bit;

    assign sgi_set[c] = (sgi_wr && wdata_i[8+c]) ? (16'(1) << wdata_i[3:0]) : '0;
    assign priv_clr   = (cpu_id_i == CPU_ID_W'(c)) ? pclr_mask[PRIV_N-1:0] : '0;
    for (genvar i = 0; i < NUM_SPI; i++) begin : g_tb
      assign tgt_bit[i] = spi_tgt_q[i][c];
    end

    irq_pend_bank #(.W(PRIV_N)) u_priv_pend (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .line_i ({ppi_i[c*PPI_N +: PPI_N], {SGI_N{1'b0}}}),
      .edge_i (priv_edge),
      .set_i  ({{PPI_N{1'b0}}, sgi_set[c]}),
      .clr_i  (priv_clr),
      .pend_o (priv_pend[c])
    );

    irq_cpu_gate #(.NSPI(NUM_SPI)) u_gate (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .glb_en_i    (ctrl_q),
      .priv_pend_i (priv_pend[c]),
      .priv_en_i   (en_priv_q[c]),
      .spi_pend_i  (spi_pend),
      .spi_en_i    (spi_en_q),
      .spi_tgt_i   (tgt_bit),
      .irq_o       (irq_o[c])
    );

    // R10
    sgi_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && addr_i == OFS_SGI && wdata_i[8+c]) |=> priv_pend[c][$past(wdata_i[3:0])]);
  end

  // read path
  logic [PRIV_N-1:0]  en_sel, pend_sel;
  logic [NUM_IRQ-1:0] en_all, pend_all, cfg_all;
  logic [TGT_W-1:0]   own_mask;
  always_comb begin
    en_sel   = '0;
    pend_sel = '0;
    for (int c = 0; c < NUM_CPU; c++)
      if (cpu_id_i == CPU_ID_W'(c)) begin
        en_sel   = en_priv_q[c];
        pend_sel = priv_pend[c];
      end
  end
  assign en_all   = {spi_en_q, en_sel};
  assign pend_all = {spi_pend, pend_sel};
  assign cfg_all  = {spi_cfg_q, ppi_cfg_q, {SGI_N{1'b1}}};
  assign own_mask = cpu_ok ? (16'(1) << cpu_id_i) : '0;

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      if (addr_i == OFS_CTRL) rdata_o = {31'b0, ctrl_q};
      if (addr_i == OFS_TYPE) rdata_o = 32'(NWORD - 1);
      for (int w = 0; w < NWORD; w++)
        if (bank_w == 5'(w)) begin
          if (in_enset || in_enclr) rdata_o = en_all[w*32 +: 32];
          if (in_pclr)              rdata_o = pend_all[w*32 +: 32];
          if (in_cfg)               rdata_o = cfg_all[w*32 +: 32];
        end
      if (in_tgt) begin
        if (tgt_w < 8'(PRIV_N / 2)) rdata_o = {own_mask, own_mask};
        for (int j = PRIV_N / 2; j < NTWORD; j++)
          if (tgt_w == 8'(j))
            rdata_o = {spi_tgt_q[2*j+1-PRIV_N], spi_tgt_q[2*j-PRIV_N]};
      end
    end
  end

  // R4
  en_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFS_ENCLR + 12'h4 && wdata_i[0]) |=> !spi_en_q[0]);
endmodule

// File: tb/irq_distributor_bench.sv
module irq_distributor_bench;
  localparam int NCPU = 4;
  localparam int NIRQ = 64;
  localparam int NSPI = NIRQ - 32;

  logic clk = 0;
  logic rst_n = 0;
  logic [11:0] addr = '0;
  logic we = 0, re = 0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0] cpu_id = '0;
  logic [NCPU*16-1:0] ppi = '0;
  logic [NSPI-1:0] spi = '0;
  logic [NCPU-1:0] irq;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_distributor #(.NUM_CPU(NCPU), .NUM_IRQ(NIRQ)) u_irq_distributor (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(we), .wdata_i(wdata),
    .rd_i(re), .rdata_o(rdata), .cpu_id_i(cpu_id), .ppi_i(ppi), .spi_i(spi), .irq_o(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input int c);
    @(negedge clk);
    addr = a; wdata = d; cpu_id = 4'(c); we = 1;
    @(negedge clk);
    we = 0;
  endtask

  task automatic rd(input logic [11:0] a, input int c, output logic [31:0] d);
    @(negedge clk);
    addr = a; cpu_id = 4'(c); re = 1;
    #1 d = rdata;
    re = 0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [15:0] tgt_of(input int i);
    return 16'((i % 15) + 1);
  endfunction

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 / R2 / R12 reset and read behaviour
    chk("R1 irq", 32'(irq), 32'h0);
    rd(12'h000, 0, d); chk("R1 ctrl", d, 0);
    rd(12'h104, 0, d); chk("R1 enables", d, 0);
    rd(12'h840, 0, d); chk("R1 target", d, 0);
    rd(12'hC04, 0, d); chk("R1 config", d, 0);
    rd(12'h004, 0, d); chk("R2 type", d, 32'(NIRQ/32 - 1));
    rd(12'h010, 0, d); chk("R12 unimpl", d, 0);
    rd(12'hF00, 0, d); chk("R12 sgi read", d, 0);
    @(negedge clk); addr = 12'h004; #1 chk("R12 no strobe", rdata, 0);

    wr(12'h000, 1, 0);
    rd(12'h000, 0, d); chk("R3 ctrl readback", d, 1);
    for (int c = 0; c < NCPU; c++) wr(12'h100, 32'h0000FFFF, c);
    rd(12'h100, 0, d); chk("R4 enset read", d, 32'h0000FFFF);
    rd(12'h180, 2, d); chk("R4 enclr read", d, 32'h0000FFFF);

    // R10 / R6 software interrupts, every CPU and ID
    for (int c = 0; c < NCPU; c++)
      for (int id = 0; id < 16; id++) begin
        wr(12'hF00, (32'(1) << (8 + c)) | 32'(id), 0);
        settle(); chk("R10 sgi route", 32'(irq), 32'(1) << c);
        rd(12'h280, c, d); chk("R6 sgi pending read", d, 32'(1) << id);
        wr(12'h280, 32'(1) << id, c);
        settle(); chk("R6 sgi clear", 32'(irq), 0);
      end
    wr(12'hF00, (32'h8F << 8) | 5, 1);
    settle(); chk("R10 multi target", 32'(irq), 32'hF);
    for (int c = 0; c < NCPU; c++) wr(12'h280, 32'h20, c);
    settle(); chk("R6 multi clear", 32'(irq), 0);

    // R4 banking and write-zero
    wr(12'h180, 32'h8, 1);
    wr(12'h180, 32'h0, 0);
    wr(12'h100, 32'h0, 1);
    rd(12'h100, 1, d); chk("R4 banked cpu1", d, 32'h0000FFF7);
    rd(12'h100, 0, d); chk("R4 banked cpu0", d, 32'h0000FFFF);
    wr(12'hF00, (32'hF << 8) | 3, 0);
    settle(); chk("R4 masked cpu1", 32'(irq), 32'hD);
    for (int c = 0; c < NCPU; c++) wr(12'h280, 32'h8, c);
    wr(12'h100, 32'h8, 1);
    settle(); chk("R4 reenabled", 32'(irq), 0);

    // R5 configuration
    rd(12'hC00, 0, d); chk("R5 sgi fixed", d, 32'h0000FFFF);
    wr(12'hC00, 32'h0, 0);
    rd(12'hC00, 0, d); chk("R5 sgi ignore", d, 32'h0000FFFF);
    wr(12'hC00, 32'hFFFF0000, 0);
    rd(12'hC00, 3, d); chk("R5 ppi edge", d, 32'hFFFFFFFF);
    wr(12'hC00, 32'h0, 0);

    // R9 private target reads
    for (int c = 0; c < NCPU; c++) begin
      rd(12'h800, c, d); chk("R9 own mask lo", d, {2{16'(1) << c}});
      rd(12'h83C, c, d); chk("R9 own mask hi", d, {2{16'(1) << c}});
    end
    wr(12'h804, 32'hFFFFFFFF, 0);
    rd(12'h804, 2, d); chk("R9 write ignored", d, 32'h00040004);

    // R8 targets, two per word
    for (int j = 0; j < NSPI/2; j++)
      wr(12'(12'h800 + 4*(16 + j)), {tgt_of(2*j+1), tgt_of(2*j)}, 0);
    rd(12'h84C, 0, d); chk("R8 target pair", d, {tgt_of(7), tgt_of(6)});
    wr(12'h104, 32'hFFFFFFFF, 0);

    // R7 / R8 / R11 level sweep
    for (int i = 0; i < NSPI; i++) begin
      spi[i] = 1;
      settle(); chk("R8 level route", 32'(irq), 32'(tgt_of(i)));
      wr(12'h284, 32'(1) << i, 0);
      settle(); chk("R7 clear ignored", 32'(irq), 32'(tgt_of(i)));
      spi[i] = 0;
      settle(); chk("R7 level drop", 32'(irq), 0);
    end

    // R6 edge sweep
    wr(12'hC04, 32'hFFFFFFFF, 0);
    for (int i = 0; i < NSPI; i++) begin
      @(negedge clk); spi[i] = 1;
      @(negedge clk); spi[i] = 0;
      settle(); chk("R6 edge latch", 32'(irq), 32'(tgt_of(i)));
      wr(12'h284, 32'(1) << i, 0);
      settle(); chk("R6 edge clear", 32'(irq), 0);
    end
    wr(12'hC04, 32'h0, 0);

    // R11 private line
    wr(12'h100, 32'h00100000, 2);
    ppi[2*16 + 4] = 1; ppi[0*16 + 4] = 1;
    settle(); chk("R11 private", 32'(irq), 32'h4);
    ppi = '0;
    settle(); chk("R11 private drop", 32'(irq), 0);

    // R3 global enable and R4 shared clear
    spi[0] = 1;
    settle(); chk("R3 baseline", 32'(irq), 32'(tgt_of(0)));
    wr(12'h000, 0, 0);
    @(negedge clk); chk("R3 forwarding off", 32'(irq), 0);
    wr(12'h000, 1, 0);
    settle(); chk("R3 forwarding on", 32'(irq), 32'(tgt_of(0)));
    wr(12'h184, 32'h1, 0);
    settle(); chk("R4 shared disabled", 32'(irq), 0);
    spi[0] = 0;

    done = 1;
    finish_run();
  end
endmodule